// File: doc/BRIEF.md
# Oversampled Serial Receiver with Sleep and Wakeup

This block receives asynchronous serial characters. It samples its input on an oversampling clock-enable, `os_tick`, which pulses OSR times per bit. The input can come from three places: the normal receive pin, the local transmitter's output looped back inside the chip, or the transmit pin's input signal for single-wire operation. Each character is a start bit, then a payload, then a stop bit. The payload holds 7, 8 or 9 data bits and an optional parity bit. The block checks parity and the stop bit, and it reports a line that has gone idle.

Software can put the receiver to sleep. While it sleeps, every received character is hidden from the consumer. The receiver wakes on one of two conditions. In address-mark mode it wakes when a character arrives whose top data bit is 1, and that character is delivered. In idle-line mode it wakes when an idle line is detected.

The output stream has no back-pressure. `out_valid` is a single-cycle strobe. The consumer must capture `out_data`, `par_err` and `frm_err` in that cycle. There is no ready input, because the serial line cannot be stalled.

Top module: `uart_wake_rx`

## Requirements
- R1: After reset, `out_valid`, `par_err`, `frm_err`, `idle_flag` and `asleep` are all 0.
- R2: The payload is 8 slots when `nine_bit`=0. It is 9 slots when `nine_bit`=1. It grows to 10 slots when `nine_bit`, `ext_len` and `par_en` are all 1. With `par_en`=1 the last slot holds parity and the other slots hold data. `out_data` is right-aligned, and its bits above the data length read 0.
- R3: With `msb_first`=0 the first data bit received is `out_data[0]`. With `msb_first`=1 the first data bit received is the top data bit.
- R4: Parity is the slot directly before the stop bit. `par_odd`=0 expects an even count of ones over data plus parity. `par_odd`=1 expects an odd count. A mismatch raises `par_err` in the same cycle as `out_valid`.
- R5: A 0 sampled in the stop position raises `frm_err` in the same cycle as `out_valid`, and the data is still delivered.
- R6: With `loop_en`=0 the receiver reads `rx_pin`, whatever `src_sel` is. With `loop_en`=1 and `src_sel`=0 it reads `tx_loop`. With `loop_en`=1 and `src_sel`=1 it reads `tx_pin_in`.
- R7: Each bit is the 2-of-3 majority of the samples at ticks OSR/2-1, OSR/2 and OSR/2+1 after the falling edge. A low pulse that is not low by majority at mid-bit is dropped and delivers nothing.
- R8: `idle_flag` pulses once when the line has held L consecutive one-bits, where L is the frame length (10, 11 or 12 bits). With `ilt_stop`=0 the count starts after the start bit. With `ilt_stop`=1 the count starts after the stop bit. The flag fires again only after a new character has started.
- R9: A pulse on `sleep_req` sets `asleep`. While `asleep`=1, `out_valid`, `par_err` and `frm_err` stay 0.
- R10: With `wake_addr`=1, a character received while asleep whose top data bit is 1 clears `asleep` and is delivered.
- R11: With `wake_addr`=0, an idle detection clears `asleep`. While asleep in this mode, `ilt_stop` is ignored and counting starts after the start bit.
- R12: `out_valid` lasts one cycle per character, and `par_err` or `frm_err` is never 1 without `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| os_tick | input | 1 | Oversampling enable, OSR pulses per bit |
| rx_pin | input | 1 | Normal receive pin |
| tx_loop | input | 1 | Local transmitter output, used for internal loopback |
| tx_pin_in | input | 1 | Input signal of the transmit pin, used in single-wire mode |
| loop_en | input | 1 | Enables the loop source selection |
| src_sel | input | 1 | Loop source: 0 internal loopback, 1 single-wire |
| nine_bit | input | 1 | Selects the 9-slot payload |
| ext_len | input | 1 | Adds a separate parity slot after 9 data bits |
| msb_first | input | 1 | Data order |
| par_en | input | 1 | Parity enable |
| par_odd | input | 1 | Parity type: 0 even, 1 odd |
| wake_addr | input | 1 | Wake method: 0 idle line, 1 address mark |
| ilt_stop | input | 1 | Idle count start: 0 after start bit, 1 after stop bit |
| sleep_req | input | 1 | Pulse that puts the receiver to sleep |
| out_valid | output | 1 | Character-ready strobe |
| out_data | output | 9 | Received data word |
| par_err | output | 1 | Parity mismatch, valid with out_valid |
| frm_err | output | 1 | Stop bit sampled low, valid with out_valid |
| idle_flag | output | 1 | Idle line detected pulse |
| asleep | output | 1 | Receiver is sleeping |

## Verification
A vector table sweeps every payload layout, both bit orders, both parity senses and a bad stop bit. A layout decoder that placed parity wrongly, or reversed the order, would return a different word or flag the wrong error. Directed tests compare the two idle-count start points on an all-ones character. A receiver that ignored `ilt_stop` would flag idle either long before the frame-length count or never. A second case shows that the setting is ignored during idle-line sleep. Further tests cover sleep with both wake methods, a short low glitch, and each source of the input multiplexer. In these tests a faulty design would leak characters while asleep, stay asleep, produce a phantom character, or read the wrong pin.

// File: rtl/uart_wake_rx_pkg.sv
package uart_wake_rx_pkg;

  localparam int WORD_W  = 9;
  localparam int MAX_PAY = 10;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP
  } rx_state_e;

  typedef struct packed {
    logic nine_bit;
    logic ext_len;
    logic par_en;
    logic par_odd;
    logic msb_first;
  } rx_fmt_t;

  // payload slots between start and stop (data plus parity)
  function automatic logic [3:0] payload_slots(rx_fmt_t f);
    return 4'd8 + {3'd0, f.nine_bit} + {3'd0, (f.nine_bit & f.ext_len & f.par_en)};
  endfunction

  function automatic logic [3:0] data_slots(rx_fmt_t f);
    return payload_slots(f) - {3'd0, f.par_en};
  endfunction

endpackage

// File: rtl/uart_rx_src.sv
module uart_rx_src #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_pin,
  input  logic tx_loop,
  input  logic tx_pin_in,
  input  logic loop_en,
  input  logic src_sel,
  output logic line
);

  logic raw;
  logic [SYNC_STAGES-1:0] sync_q;

  always_comb begin
    if (!loop_en)     raw = rx_pin;
    else if (src_sel) raw = tx_pin_in;
    else              raw = tx_loop;
  end

  generate
    if (SYNC_STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= raw;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], raw};
      end
    end
  endgenerate

  assign line = sync_q[SYNC_STAGES-1];

endmodule

// File: rtl/uart_rx_sampler.sv
module uart_rx_sampler #(
  parameter int OSR = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic line,
  input  logic hunt,
  output logic start_edge,
  output logic bit_strobe,
  output logic bit_val
);

  localparam int PW = $clog2(OSR);
  localparam logic [PW-1:0] PH_EARLY = PW'(OSR/2 - 1);
  localparam logic [PW-1:0] PH_MID   = PW'(OSR/2);
  localparam logic [PW-1:0] PH_LATE  = PW'(OSR/2 + 1);
  localparam logic [PW-1:0] PH_LAST  = PW'(OSR - 1);

  logic [PW-1:0] phase;
  logic [1:0]    early;

  assign start_edge = hunt & tick & ~line;
  assign bit_strobe = ~hunt & tick & (phase == PH_LATE);
  assign bit_val    = (early[0] & early[1]) | (early[0] & line) | (early[1] & line);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= '0;
      early <= 2'b11;
    end else if (hunt) begin
      phase <= start_edge ? PW'(1) : '0;
    end else if (tick) begin
      phase <= (phase == PH_LAST) ? '0 : phase + PW'(1);
      if (phase == PH_EARLY) early[0] <= line;
      if (phase == PH_MID)   early[1] <= line;
    end
  end

endmodule

// File: rtl/uart_rx_idle.sv
module uart_rx_idle #(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       line,
  input  logic       hunt,
  input  logic       start_ok,
  input  logic       frame_bit,
  input  logic       stop_bit,
  input  logic       bit_val,
  input  logic       from_stop,
  input  logic [3:0] frame_len,
  output logic       idle_pulse
);

  localparam int PW = $clog2(OSR);
  localparam logic [PW-1:0] PH_LAST = PW'(OSR - 1);

  logic [PW-1:0] ph;
  logic [3:0]    ones;
  logic          armed;
  logic          bump;

  assign bump = hunt & tick & line & (ph == PH_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= '0;
    end else if (!hunt || (tick && !line)) begin
      ph <= '0;
    end else if (tick) begin
      ph <= (ph == PH_LAST) ? '0 : ph + PW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ones       <= '0;
      armed      <= 1'b0;
      idle_pulse <= 1'b0;
    end else begin
      idle_pulse <= 1'b0;
      if (start_ok) begin
        ones  <= '0;
        armed <= 1'b1;
      end else begin
        if (frame_bit) begin
          if (!bit_val || (stop_bit && from_stop)) ones <= '0;
          else if (ones != 4'hF)                   ones <= ones + 4'd1;
        end else if (bump && ones != 4'hF) begin
          ones <= ones + 4'd1;
        end
        if (armed && ones >= frame_len) begin
          idle_pulse <= 1'b1;
          armed      <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/uart_wake_rx.sv
module uart_wake_rx
  import uart_wake_rx_pkg::*;
#(
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              os_tick,
  input  logic              rx_pin,
  input  logic              tx_loop,
  input  logic              tx_pin_in,
  input  logic              loop_en,
  input  logic              src_sel,
  input  logic              nine_bit,
  input  logic              ext_len,
  input  logic              msb_first,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              wake_addr,
  input  logic              ilt_stop,
  input  logic              sleep_req,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_data,
  output logic              par_err,
  output logic              frm_err,
  output logic              idle_flag,
  output logic              asleep
);

  rx_fmt_t             fmt;
  rx_state_e           state;
  logic [3:0]          idx;
  logic [MAX_PAY-1:0]  pay;
  logic [3:0]          pay_n, dat_n, frame_len;
  logic                line, hunt, start_edge, bit_strobe, bit_val;
  logic                start_ok, frame_done, idle_pulse, from_stop;
  logic [WORD_W-1:0]   word;
  logic                par_rx, par_exp, top_bit;
  logic                wake_by_addr, wake_by_idle, deliver;

  always_comb begin
    fmt.nine_bit  = nine_bit;
    fmt.ext_len   = ext_len;
    fmt.par_en    = par_en;
    fmt.par_odd   = par_odd;
    fmt.msb_first = msb_first;
  end

  assign pay_n     = payload_slots(fmt);
  assign dat_n     = data_slots(fmt);
  assign frame_len = pay_n + 4'd2;

  uart_rx_src #(.SYNC_STAGES(SYNC_STAGES)) u_src (
    .clk(clk), .rst_n(rst_n), .rx_pin(rx_pin), .tx_loop(tx_loop),
    .tx_pin_in(tx_pin_in), .loop_en(loop_en), .src_sel(src_sel), .line(line)
  );

  assign hunt = (state == ST_IDLE);

  uart_rx_sampler #(.OSR(OSR)) u_smp (
    .clk(clk), .rst_n(rst_n), .tick(os_tick), .line(line), .hunt(hunt),
    .start_edge(start_edge), .bit_strobe(bit_strobe), .bit_val(bit_val)
  );

  assign start_ok   = (state == ST_START) & bit_strobe & ~bit_val;
  assign frame_done = (state == ST_STOP) & bit_strobe;
  assign from_stop  = ilt_stop & ~(asleep & ~wake_addr);

  uart_rx_idle #(.OSR(OSR)) u_idle (
    .clk(clk), .rst_n(rst_n), .tick(os_tick), .line(line), .hunt(hunt),
    .start_ok(start_ok),
    .frame_bit(bit_strobe & ((state == ST_DATA) | (state == ST_STOP))),
    .stop_bit(state == ST_STOP), .bit_val(bit_val), .from_stop(from_stop),
    .frame_len(frame_len), .idle_pulse(idle_pulse)
  );

  // frame sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      idx   <= '0;
      pay   <= '0;
    end else begin
      case (state)
        ST_IDLE:  if (start_edge) state <= ST_START;
        ST_START: if (bit_strobe) begin
          if (!bit_val) begin
            state <= ST_DATA;
            idx   <= '0;
            pay   <= '0;
          end else begin
            state <= ST_IDLE;
          end
        end
        ST_DATA: if (bit_strobe) begin
          pay[idx] <= bit_val;
          if (idx == pay_n - 4'd1) state <= ST_STOP;
          else                     idx   <= idx + 4'd1;
        end
        ST_STOP: if (bit_strobe) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // payload to word, honouring bit order; parity slot follows the data
  always_comb begin
    word = '0;
    for (int i = 0; i < WORD_W; i++) begin
      if (i < int'(dat_n)) begin
        if (msb_first) word[i] = pay[int'(dat_n) - 1 - i];
        else           word[i] = pay[i];
      end
    end
    par_rx  = pay[dat_n];
    par_exp = (^word) ^ par_odd;
    top_bit = word[dat_n - 4'd1];
  end

  assign wake_by_addr = asleep & wake_addr & frame_done & top_bit;
  assign wake_by_idle = asleep & ~wake_addr & idle_pulse;
  assign deliver      = frame_done & (~asleep | wake_by_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      par_err   <= 1'b0;
      frm_err   <= 1'b0;
      asleep    <= 1'b0;
    end else begin
      out_valid <= deliver;
      par_err   <= deliver & par_en & (par_rx != par_exp);
      frm_err   <= deliver & ~bit_val;
      if (deliver) out_data <= word;
      if (sleep_req)                        asleep <= 1'b1;
      else if (wake_by_addr | wake_by_idle) asleep <= 1'b0;
    end
  end

  assign idle_flag = idle_pulse;

endmodule

// File: rtl/uart_wake_rx_chk.sv
module uart_wake_rx_chk
  import uart_wake_rx_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input logic      out_valid,
  input logic      par_err,
  input logic      frm_err,
  input logic      asleep,
  input logic      idle_flag,
  input logic      wake_addr,
  input logic      sleep_req,
  input rx_state_e state,
  input logic      bit_strobe,
  input logic      bit_val
);

  assert_flags_need_valid_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (par_err || frm_err) |-> out_valid);

  assert_valid_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  assert_sleep_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_req |=> asleep);

  assert_quiet_asleep_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (!asleep || $past(sleep_req)));

  assert_addr_wake_delivers_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(asleep) && $past(wake_addr)) |-> out_valid);

  assert_idle_wake_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(asleep) && !$past(wake_addr)) |-> $past(idle_flag));

  assert_start_confirmed_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DATA && $past(state) == ST_START) |-> ($past(bit_strobe) && !$past(bit_val)));

endmodule

bind uart_wake_rx uart_wake_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .par_err(par_err),
  .frm_err(frm_err), .asleep(asleep), .idle_flag(idle_flag),
  .wake_addr(wake_addr), .sleep_req(sleep_req), .state(state),
  .bit_strobe(bit_strobe), .bit_val(bit_val)
);

// File: tb/sim_uart_wake_rx.sv
module sim_uart_wake_rx;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic os_tick = 1'b1;
  logic rx_pin = 1'b1, tx_loop = 1'b1, tx_pin_in = 1'b1;
  logic loop_en = 1'b0, src_sel = 1'b0;
  logic nine_bit = 1'b0, ext_len = 1'b0, msb_first = 1'b0;
  logic par_en = 1'b0, par_odd = 1'b0;
  logic wake_addr = 1'b0, ilt_stop = 1'b0, sleep_req = 1'b0;
  logic out_valid, par_err, frm_err, idle_flag, asleep;
  logic [8:0] out_data;

  uart_wake_rx u0 (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rx_pin(rx_pin),
    .tx_loop(tx_loop), .tx_pin_in(tx_pin_in), .loop_en(loop_en),
    .src_sel(src_sel), .nine_bit(nine_bit), .ext_len(ext_len),
    .msb_first(msb_first), .par_en(par_en), .par_odd(par_odd),
    .wake_addr(wake_addr), .ilt_stop(ilt_stop), .sleep_req(sleep_req),
    .out_valid(out_valid), .out_data(out_data), .par_err(par_err),
    .frm_err(frm_err), .idle_flag(idle_flag), .asleep(asleep)
  );

  int total = 0, bad = 0;
  int nvalid = 0, nidle = 0;
  logic [8:0] got_data = '0;
  logic got_perr = 1'b0, got_ferr = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid) begin
        nvalid   <= nvalid + 1;
        got_data <= out_data;
        got_perr <= par_err;
        got_ferr <= frm_err;
      end
      if (idle_flag) nidle <= nidle + 1;
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // vector fields: [15]nine_bit [14]ext_len [13]par_en [12]par_odd
  // [11]msb_first [10]corrupt parity [9]stop value [8:0]data
  localparam int NV = 9;
  localparam logic [15:0] VEC [NV] = '{
    16'h025A, 16'h0A31, 16'h83A5, 16'h8B0F, 16'h2253,
    16'hBEC3, 16'hE3F0, 16'h00A5, 16'hFEFF
  };

  task automatic put_bit(input int which, input logic v);
    @(negedge clk);
    case (which)
      0: rx_pin = v;
      1: tx_loop = v;
      default: tx_pin_in = v;
    endcase
    repeat (15) @(negedge clk);
  endtask

  function automatic int dlen_of(input logic [15:0] v);
    return 8 + int'(v[15]) + int'(v[15] & v[14] & v[13]) - int'(v[13]);
  endfunction

  function automatic logic [8:0] exp_word(input logic [15:0] v);
    return v[8:0] & 9'((1 << dlen_of(v)) - 1);
  endfunction

  task automatic send(input int which, input logic [15:0] v, input int gap);
    int dl;
    logic [8:0] d;
    logic p;
    nine_bit = v[15]; ext_len = v[14]; par_en = v[13];
    par_odd = v[12]; msb_first = v[11];
    dl = dlen_of(v);
    d  = exp_word(v);
    p  = (^d) ^ v[12] ^ v[10];
    put_bit(which, 1'b0);
    for (int i = 0; i < dl; i++) put_bit(which, v[11] ? d[dl-1-i] : d[i]);
    if (v[13]) put_bit(which, p);
    put_bit(which, v[9]);
    for (int g = 0; g < gap; g++) put_bit(which, 1'b1);
  endtask

  task automatic nap();
    @(negedge clk); sleep_req = 1'b1;
    @(negedge clk); sleep_req = 1'b0;
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "out_valid", out_valid, 0);
    check("R1", "asleep", asleep, 0);
    check("R1", "idle_flag", idle_flag, 0);
    check("R1", "errors", {par_err, frm_err}, 0);

    // table: formats R2, order R3, parity R4, stop R5, single strobe R12
    for (int k = 0; k < NV; k++) begin
      n0 = nvalid;
      send(0, VEC[k], 2);
      check("R12", $sformatf("vec%0d strobes", k), nvalid - n0, 1);
      check(VEC[k][11] ? "R3" : "R2", $sformatf("vec%0d data", k), got_data, exp_word(VEC[k]));
      check("R4", $sformatf("vec%0d par_err", k), got_perr, VEC[k][13] & VEC[k][10]);
      check("R5", $sformatf("vec%0d frm_err", k), got_ferr, !VEC[k][9]);
    end

    // R7 short low glitch gives no character
    n0 = nvalid;
    @(negedge clk); rx_pin = 1'b0;
    repeat (4) @(negedge clk); rx_pin = 1'b1;
    repeat (48) @(negedge clk);
    check("R7", "glitch strobes", nvalid - n0, 0);

    // R6 source selection
    loop_en = 1'b1; src_sel = 1'b0; rx_pin = 1'b0; tx_pin_in = 1'b0;
    n0 = nvalid;
    send(1, 16'h023C, 2);
    check("R6", "loopback data", got_data, 9'h03C);
    check("R6", "loopback count", nvalid - n0, 1);
    rx_pin = 1'b1; tx_pin_in = 1'b1;
    repeat (20) @(negedge clk);
    src_sel = 1'b1;
    repeat (4) @(negedge clk);
    rx_pin = 1'b0; tx_loop = 1'b0;
    send(2, 16'h0296, 2);
    check("R6", "single-wire data", got_data, 9'h096);
    rx_pin = 1'b1; tx_loop = 1'b1;
    repeat (20) @(negedge clk);
    loop_en = 1'b0;
    repeat (4) @(negedge clk);
    tx_loop = 1'b0; tx_pin_in = 1'b0;
    n0 = nvalid;
    send(0, 16'h0269, 2);
    check("R6", "pin data with loop off", got_data, 9'h069);
    check("R6", "pin count with loop off", nvalid - n0, 1);
    tx_loop = 1'b1; tx_pin_in = 1'b1;
    repeat (20) @(negedge clk);

    // R8 idle counting, frame length 10
    ilt_stop = 1'b0; nidle = 0;
    send(0, 16'h02FF, 3);
    check("R8", "idle after start-bit count", nidle, 1);
    ilt_stop = 1'b1; nidle = 0;
    send(0, 16'h02FF, 9);
    check("R8", "no idle before 10 after stop", nidle, 0);
    repeat (2) put_bit(0, 1'b1);
    check("R8", "idle after 10 after stop", nidle, 1);
    repeat (15) put_bit(0, 1'b1);
    check("R8", "idle fires once", nidle, 1);
    // R8 frame length 12
    nidle = 0;
    send(0, 16'hE2FF, 11);
    check("R8", "no idle before 12", nidle, 0);
    repeat (2) put_bit(0, 1'b1);
    check("R8", "idle at 12", nidle, 1);

    // R9/R10 address-mark wake
    wake_addr = 1'b1; ilt_stop = 1'b0;
    nap();
    check("R9", "asleep set", asleep, 1);
    n0 = nvalid;
    send(0, 16'h0212, 2);
    check("R9", "suppressed while asleep", nvalid - n0, 0);
    check("R10", "still asleep on plain char", asleep, 1);
    send(0, 16'h0285, 2);
    check("R10", "address char delivered", nvalid - n0, 1);
    check("R10", "address char data", got_data, 9'h085);
    check("R10", "awake after mark", asleep, 0);
    send(0, 16'h0212, 2);
    check("R10", "later char delivered", nvalid - n0, 2);

    // R11 idle-line wake, stop-bit count start ignored while asleep
    wake_addr = 1'b0; ilt_stop = 1'b1;
    nap();
    n0 = nvalid;
    send(0, 16'h02FF, 3);
    check("R11", "suppressed before wake", nvalid - n0, 0);
    check("R11", "awake after early idle", asleep, 0);
    send(0, 16'h0244, 2);
    check("R11", "delivered after wake", got_data, 9'h044);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule